// File: doc/BRIEF.md
# Self-Correcting Three-Bit Sequence Controller

This block is a clocked state machine driven by one serial input bit `x`. Its state is held in three D flip-flops. Bit 2 of the state is the most significant. Five encodings (000 through 100) are working states and three encodings (101, 110, 111) are unused. The next state comes from three fixed sum-of-products equations, one per flip-flop. There is no default branch that forces an unused state home. Instead, the equations give every encoding a defined successor, and every unused encoding returns to a working state within two clock edges for any input.

The present state is driven out on `state`. The `illegal` flag is raised while the register holds an unused encoding. A synchronous load port can place any of the eight encodings in the register. This lets recovery from upset or power-up states be exercised directly. Input `x` is sampled only on the rising clock edge and must meet setup and hold around that edge.

The states are named REST (000), ARM (001), MID (010), PEAK (011) and HOLD (100). The unused states are FIVE (101), SIX (110) and SEVEN (111).

Top module: `sc3_ctrl`

## Requirements
- R1: With `rst` high at a rising edge, the state becomes 000 (REST). This overrides `load_en`.
- R2: With `rst` low and `load_en` high at a rising edge, the state becomes `load_val`, whatever the value of `x`.
- R3: With `rst` and `load_en` low, the working states move as follows (successor for x=0 / successor for x=1):
  - REST 000 goes to 000 / 001.
  - ARM 001 goes to 010 / 011.
  - MID 010 goes to 100 / 000.
  - PEAK 011 goes to 010 / 100.
  - HOLD 100 goes to 100 / 000.
- R4: With `rst` and `load_en` low, the unused states move as follows (successor for x=0 / successor for x=1):
  - FIVE 101 goes to 110 / 010.
  - SIX 110 goes to 100 / 000.
  - SEVEN 111 goes to 110 / 100.
- R5: `illegal` is high exactly while `state` is 101, 110 or 111. It is combinational from the register.
- R6: Starting from a working state with no load or reset, the machine never enters an unused state.
- R7: No unused state transitions to itself, and SIX never goes to FIVE or SEVEN.
- R8: From any unused state, for any two input bits, the state is a working one after at most two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset to 000 |
| x | input | 1 | Serial control input, sampled at the rising edge |
| load_en | input | 1 | Synchronous test-load enable |
| load_val | input | 3 | Encoding loaded when `load_en` is high |
| state | output | 3 | Present state, bit 2 most significant |
| illegal | output | 1 | High while the state is an unused encoding |

## Verification
The assertions check the following on every cycle: reset and load take effect, working states stay closed, no unused state holds, SIX never returns to FIVE or SEVEN, and recovery takes at most two steps. Only the bench scenarios can show that each of the sixteen state and input pairs lands on the exact successor in the table. The same holds for exact recovery paths from each unused state under all four two-bit input sequences, for the exact value of `illegal` in all eight encodings, and for a long walk through the working states that follows a reference model.

// File: rtl/sc3_pkg.sv
package sc3_pkg;
    localparam int STW = 3;

    typedef enum logic [STW-1:0] {
        ST_REST  = 3'b000,
        ST_ARM   = 3'b001,
        ST_MID   = 3'b010,
        ST_PEAK  = 3'b011,
        ST_HOLD  = 3'b100,
        UN_FIVE  = 3'b101,
        UN_SIX   = 3'b110,
        UN_SEVEN = 3'b111
    } sc3_state_e;
endpackage

// File: rtl/sc3_next.sv
module sc3_next
    import sc3_pkg::*;
(
    input  sc3_state_e cur,
    input  logic       x,
    output sc3_state_e nxt
);
    logic a, b, c;
    logic na, nb, nc;

    always_comb begin
        {a, b, c} = cur;
        // flip-flop input equations, valid for all eight encodings
        na = (b & ~c & ~x) | (b & c & x) | (a & ~x);
        nb = (~b & c) | (c & ~x);
        nc = ~a & ~b & x;
        nxt = sc3_state_e'({na, nb, nc});
    end
endmodule

// File: rtl/sc3_guard.sv
module sc3_guard
    import sc3_pkg::*;
(
    input  sc3_state_e cur,
    output logic       illegal
);
    always_comb begin
        unique case (cur)
            ST_REST, ST_ARM, ST_MID, ST_PEAK, ST_HOLD: illegal = 1'b0;
            UN_FIVE, UN_SIX, UN_SEVEN:                 illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/sc3_ctrl.sv
module sc3_ctrl
    import sc3_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           x,
    input  logic           load_en,
    input  logic [STW-1:0] load_val,
    output logic [STW-1:0] state,
    output logic           illegal
);
    sc3_state_e cur, nxt;

    sc3_next u_next (.cur(cur), .x(x), .nxt(nxt));
    sc3_guard u_guard (.cur(cur), .illegal(illegal));

    always_ff @(posedge clk) begin
        if (rst)          cur <= ST_REST;
        else if (load_en) cur <= sc3_state_e'(load_val);
        else              cur <= nxt;
    end

    always_comb state = cur;

    // R1
    reset_home_chk: assert property (@(posedge clk) rst |=> state == 3'b000);

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |=> state == $past(load_val));

    // R6
    legal_closed_chk: assert property (@(posedge clk) disable iff (rst)
        (!illegal && !load_en) |=> !illegal);

    // R7
    no_self_loop_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal && !load_en) |=> state != $past(state));

    // R7
    six_no_back_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b110 && !load_en) |=> (state != 3'b101 && state != 3'b111));

    // R8
    first_step_chk: assert property (@(posedge clk) disable iff (rst)
        (illegal && !load_en) |=> (!illegal || state == 3'b110));

    // R8
    second_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'b110 && !load_en) |=> !illegal);
endmodule

// File: tb/test_sc3_ctrl.sv
`timescale 1ns/100ps
module test_sc3_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x = 1'b0;
    logic load_en = 1'b0;
    logic [2:0] load_val = 3'b000;
    logic [2:0] state;
    logic illegal;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sc3_ctrl i_sc3_ctrl (.clk(clk), .rst(rst), .x(x), .load_en(load_en),
                         .load_val(load_val), .state(state), .illegal(illegal));

    function automatic logic [2:0] ref_next(logic [2:0] s, logic xi);
        case (s)
            3'b000: return xi ? 3'b001 : 3'b000;
            3'b001: return xi ? 3'b011 : 3'b010;
            3'b010: return xi ? 3'b000 : 3'b100;
            3'b011: return xi ? 3'b100 : 3'b010;
            3'b100: return xi ? 3'b000 : 3'b100;
            3'b101: return xi ? 3'b010 : 3'b110;
            3'b110: return xi ? 3'b000 : 3'b100;
            default: return xi ? 3'b100 : 3'b110;
        endcase
    endfunction

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step(logic r, logic le, logic [2:0] lv, logic xi);
        @(negedge clk);
        rst = r; load_en = le; load_val = lv; x = xi;
        @(posedge clk);
        #1;
        rst = 1'b0; load_en = 1'b0;
    endtask

    task automatic test_reset();
        step(1'b0, 1'b1, 3'b011, 1'b0);
        step(1'b1, 1'b1, 3'b111, 1'b1);
        chk("R1 reset over load", state, 3'b000);
        chk("R5 flag after reset", {2'b0, illegal}, 3'b000);
    endtask

    task automatic test_load();
        for (int v = 0; v < 8; v++) begin
            step(1'b0, 1'b1, 3'(v), v[0]);
            chk("R2 load", state, 3'(v));
            chk("R5 flag", {2'b0, illegal}, {2'b0, (v >= 5)});
        end
    endtask

    task automatic test_table();
        for (int v = 0; v < 8; v++) begin
            for (int xi = 0; xi < 2; xi++) begin
                step(1'b0, 1'b1, 3'(v), 1'b0);
                step(1'b0, 1'b0, 3'b000, xi[0]);
                if (v < 5) chk("R3 legal step", state, ref_next(3'(v), xi[0]));
                else       chk("R4 unused step", state, ref_next(3'(v), xi[0]));
            end
        end
    endtask

    task automatic test_recovery();
        for (int v = 5; v < 8; v++) begin
            for (int q = 0; q < 4; q++) begin
                logic [2:0] mid;
                step(1'b0, 1'b1, 3'(v), 1'b0);
                step(1'b0, 1'b0, 3'b000, q[0]);
                mid = state;
                chk("R7 no self loop", {2'b0, mid == 3'(v)}, 3'b000);
                if (mid == 3'b110 && v == 6) chk("R7 six stays", 3'b000, 3'b001);
                step(1'b0, 1'b0, 3'b000, q[1]);
                if (mid == 3'b110)
                    chk("R7 six not to 5/7",
                        {2'b0, (state == 3'b101 || state == 3'b111)}, 3'b000);
                chk("R8 legal within two", {2'b0, illegal}, 3'b000);
                chk("R8 path", state, ref_next(ref_next(3'(v), q[0]), q[1]));
            end
        end
    endtask

    task automatic test_walk();
        logic [2:0] model;
        logic [7:0] lfsr;
        lfsr = 8'hA5;
        step(1'b1, 1'b0, 3'b000, 1'b0);
        model = 3'b000;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(1'b0, 1'b0, 3'b000, lfsr[0]);
            model = ref_next(model, lfsr[0]);
            chk("R3 walk", state, model);
            chk("R6 stays legal", {2'b0, illegal}, 3'b000);
        end
    endtask

    initial begin
        test_reset();
        test_load();
        test_table();
        test_recovery();
        test_walk();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule